// File: doc/BRIEF.md
# Bit-stuffing NRZI serial packet transmitter

This block turns the serial bit stream of one packet into the single-ended line level for a USB link. A packet request raises output-enable and starts a self-generated sync field. Packet bits are then pulled from the upstream source one at a time through a ready handshake. A zero is inserted after every run of six ones. The stuffed stream is NRZI-encoded, so a zero flips the line and a one holds it. The packet closes with a two-bit-time end-of-packet marker and one bit time of idle J. Output-enable then drops.

Each symbol lasts `CLKS_PER_BIT` clock cycles. The upstream source requests a packet by pulsing `pktStart` while the block is idle. It then presents the first packet bit on `txBit`, with `txLast` marking the final bit. A bit is taken at the end of every bit time during which `txReady` is high. The source changes `txBit` only after that. Ready goes low for the bit time before a stuff zero. It is also low for the sync bits that come before the last one, and for the close of the packet. As a result no packet bit is lost or repeated.

Top module: `usb_nrzi_stuff_tx`

## Requirements
- R1: While idle, `lineEn` is 0, `lineData` rests at J (1), `lineEop` is 0 and `txReady` is 0.
- R2: A `pktStart` pulse while idle begins the packet on the next clock with output-enable high. The block first sends `SYNC_LEN` sync symbols: all zeros except a final one. With the default of 8, the line levels are 0,1,0,1,0,1,0,0.
- R3: The NRZI encoder starts from J at each packet start. A symbol 0 toggles the line and a symbol 1 leaves it unchanged.
- R4: After `RUN_LIMIT` (6) consecutive one symbols, a zero symbol is inserted. The run count returns to zero on every zero symbol, inserted or not.
- R5: The final one of the sync field counts toward the run. A packet that opens with five ones gets a stuff zero directly after its fifth bit.
- R6: Stuffing is never skipped. When the last packet bit completes a run of six ones, the stuff zero is sent before the end-of-packet marker.
- R7: `txReady` is high in exactly those bit times at whose end a packet bit is taken: the last sync symbol, a packet bit not followed by a stuff zero, and a stuff zero while packet bits remain. It is low in every other bit time, including the end-of-packet marker.
- R8: After the last symbol, `lineEop` is high with `lineData` at 0 for `EOP_BITS` (2) bit times. Then one bit time of J follows with `lineEop` low and `lineEn` still high, after which `lineEn` falls.
- R9: While output-enable is high outside the end-of-packet marker, the line never stays at one level longer than `RUN_LIMIT`+1 bit times.
- R10: Every symbol, marker bit and J bit occupies exactly `CLKS_PER_BIT` consecutive clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pktStart | input | 1 | Packet request, honoured while idle |
| txBit | input | 1 | Current packet bit from the source |
| txLast | input | 1 | Marks `txBit` as the final packet bit |
| txReady | output | 1 | High during a bit time whose end takes `txBit` |
| lineData | output | 1 | NRZI line level (1 = J) |
| lineEn | output | 1 | Output-enable for the line driver |
| lineEop | output | 1 | End-of-packet marker |

## Verification
The bench builds the block with `CLKS_PER_BIT` = 3 and leaves `RUN_LIMIT`, `SYNC_LEN` and `EOP_BITS` at 6, 8 and 2. The three-cycle bit time checks that outputs hold steady for the whole symbol and that a bit is taken only at the symbol edge. A one-cycle bit time would hide both. The default run limit and sync length make the sync-one carry-over case and the stuff-before-end case each reachable with packets only five to fourteen bits long.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SYNC  = 3'd1,
    ST_DATA  = 3'd2,
    ST_STUFF = 3'd3,
    ST_EOP   = 3'd4,
    ST_JIDLE = 3'd5
  } tx_state_e;

  // Strobes from the sequencer to the line datapath, all valid for one clock.
  typedef struct packed {
    logic startPkt;  // load the encoder with J and restart the bit timer
    logic emitBit;   // a new symbol enters the line
    logic bitVal;    // value of that symbol before NRZI
    logic emitEop;   // first end-of-packet bit time
    logic emitJ;     // closing J bit time
    logic endPkt;    // drop output-enable
  } tx_strobe_t;

endpackage

// File: rtl/tx_line_path.sv
module tx_line_path
  import usb_tx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 4,
  parameter int RUN_LIMIT    = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  tx_strobe_t strb,
  output logic       tick,
  output logic       onesFull,
  output logic       lineOut,
  output logic       enOut,
  output logic       eopOut
);

  localparam int TW       = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int CW       = $clog2(RUN_LIMIT + 1);
  localparam int MAX_FLAT = (RUN_LIMIT + 1) * CLKS_PER_BIT;
  localparam int FW       = $clog2(MAX_FLAT + 1) + 1;
  localparam logic LVL_J  = 1'b1;

  logic [TW-1:0] timer;
  logic [CW-1:0] onesCnt;
  logic [CW-1:0] onesNext;
  logic          lineQ;
  logic          lineBase;
  logic          enQ;
  logic          eopQ;

  assign tick     = enQ && (timer == TW'(CLKS_PER_BIT - 1));
  assign onesFull = (onesCnt == CW'(RUN_LIMIT));

  // Bit timer: one symbol per CLKS_PER_BIT clocks.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timer <= '0;
    end else if (strb.startPkt) begin
      timer <= '0;
    end else if (enQ) begin
      timer <= tick ? '0 : timer + TW'(1);
    end
  end

  // Run-of-ones count, cleared by any zero symbol and at packet start.
  always_comb begin
    onesNext = strb.startPkt ? '0 : onesCnt;
    if (strb.emitBit) begin
      onesNext = strb.bitVal ? onesNext + CW'(1) : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) onesCnt <= '0;
    else       onesCnt <= onesNext;
  end

  // NRZI encoder and line state.
  assign lineBase = strb.startPkt ? LVL_J : lineQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineQ <= LVL_J;
      enQ   <= 1'b0;
      eopQ  <= 1'b0;
    end else begin
      if (strb.emitBit) begin
        lineQ <= strb.bitVal ? lineBase : ~lineBase;
        eopQ  <= 1'b0;
      end else if (strb.emitEop) begin
        lineQ <= 1'b0;
        eopQ  <= 1'b1;
      end else if (strb.emitJ) begin
        lineQ <= LVL_J;
        eopQ  <= 1'b0;
      end else if (strb.endPkt) begin
        lineQ <= LVL_J;
        eopQ  <= 1'b0;
      end
      if (strb.startPkt)    enQ <= 1'b1;
      else if (strb.endPkt) enQ <= 1'b0;
    end
  end

  assign lineOut = lineQ;
  assign enOut   = enQ;
  assign eopOut  = eopQ;

  // Cycles since the last line change, used by the transition-density check.
  logic          linePrev;
  logic [FW-1:0] flatCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linePrev <= LVL_J;
      flatCnt  <= '0;
    end else begin
      linePrev <= lineQ;
      if (!enQ || eopQ || (lineQ != linePrev)) flatCnt <= '0;
      else                                     flatCnt <= flatCnt + FW'(1);
    end
  end

  // R4: the run count never exceeds the limit.
  a_r4_run_bound: assert property (@(posedge clk) disable iff (!rstN)
    onesCnt <= CW'(RUN_LIMIT));

  // R4 / R6: a full run at a symbol edge is followed by a toggling zero.
  a_r6_stuff_toggles: assert property (@(posedge clk) disable iff (!rstN)
    (tick && onesFull) |=> (onesCnt == '0) && !eopQ && (lineQ != $past(lineQ)));

  // R9: the line never sits flat for more than RUN_LIMIT+1 bit times.
  a_r9_transition_density: assert property (@(posedge clk) disable iff (!rstN)
    flatCnt < FW'(MAX_FLAT));

endmodule

// File: rtl/tx_seq_ctrl.sv
module tx_seq_ctrl
  import usb_tx_pkg::*;
#(
  parameter int SYNC_LEN = 8,
  parameter int EOP_BITS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       onesFull,
  input  logic       pktStart,
  input  logic       txBit,
  input  logic       txLast,
  output tx_strobe_t strb,
  output logic       txReady
);

  localparam int SW = (SYNC_LEN > 1) ? $clog2(SYNC_LEN) : 1;
  localparam int EW = (EOP_BITS > 1) ? $clog2(EOP_BITS) : 1;
  localparam logic [SW-1:0] SYNC_LAST = SW'(SYNC_LEN - 1);
  localparam logic [EW-1:0] EOP_LAST  = EW'(EOP_BITS - 1);

  tx_state_e     state, stateN;
  logic [SW-1:0] syncIdx, syncIdxN;
  logic [EW-1:0] eopIdx, eopIdxN;
  logic          lastSent, lastSentN;
  logic          takeBit;

  // A packet bit is taken at the end of the current bit time.
  assign takeBit = ((state == ST_SYNC) && (syncIdx == SYNC_LAST) && !onesFull)
                 || ((state == ST_DATA) && !lastSent && !onesFull)
                 || ((state == ST_STUFF) && !lastSent);
  assign txReady = takeBit;

  always_comb begin
    strb      = '0;
    stateN    = state;
    syncIdxN  = syncIdx;
    eopIdxN   = eopIdx;
    lastSentN = lastSent;

    if (state == ST_IDLE) begin
      if (pktStart) begin
        strb.startPkt = 1'b1;
        strb.emitBit  = 1'b1;
        strb.bitVal   = (SYNC_LEN == 1);
        syncIdxN      = '0;
        lastSentN     = 1'b0;
        stateN        = ST_SYNC;
      end
    end else if (tick) begin
      if ((state == ST_SYNC) && (syncIdx != SYNC_LAST)) begin
        strb.emitBit = 1'b1;
        strb.bitVal  = (syncIdx + SW'(1) == SYNC_LAST);
        syncIdxN     = syncIdx + SW'(1);
      end else if (takeBit) begin
        strb.emitBit = 1'b1;
        strb.bitVal  = txBit;
        lastSentN    = txLast;
        stateN       = ST_DATA;
      end else if (((state == ST_SYNC) || (state == ST_DATA)) && onesFull) begin
        strb.emitBit = 1'b1;
        strb.bitVal  = 1'b0;
        stateN       = ST_STUFF;
      end else if ((state == ST_SYNC) || (state == ST_DATA) || (state == ST_STUFF)) begin
        strb.emitEop = 1'b1;
        eopIdxN      = '0;
        stateN       = ST_EOP;
      end else if (state == ST_EOP) begin
        if (eopIdx == EOP_LAST) begin
          strb.emitJ = 1'b1;
          stateN     = ST_JIDLE;
        end else begin
          eopIdxN = eopIdx + EW'(1);
        end
      end else begin
        strb.endPkt = 1'b1;
        stateN      = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      syncIdx  <= '0;
      eopIdx   <= '0;
      lastSent <= 1'b0;
    end else begin
      state    <= stateN;
      syncIdx  <= syncIdxN;
      eopIdx   <= eopIdxN;
      lastSent <= lastSentN;
    end
  end

  // R7: no bit is taken once the final packet bit has gone out.
  a_r7_no_take_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (lastSent && (state != ST_IDLE) && (state != ST_SYNC)) |-> !txReady);

  // R6: a full run when the last bit has gone out leads to a stuff slot, not the marker.
  a_r6_stuff_before_eop: assert property (@(posedge clk) disable iff (!rstN)
    (tick && onesFull && lastSent && (state == ST_DATA)) |=> (state == ST_STUFF));

endmodule

// File: rtl/usb_nrzi_stuff_tx.sv
module usb_nrzi_stuff_tx
  import usb_tx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 4,
  parameter int RUN_LIMIT    = 6,
  parameter int SYNC_LEN     = 8,
  parameter int EOP_BITS     = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pktStart,
  input  logic txBit,
  input  logic txLast,
  output logic txReady,
  output logic lineData,
  output logic lineEn,
  output logic lineEop
);

  tx_strobe_t strb;
  logic       tick;
  logic       onesFull;

  tx_seq_ctrl #(
    .SYNC_LEN (SYNC_LEN),
    .EOP_BITS (EOP_BITS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .onesFull (onesFull),
    .pktStart (pktStart),
    .txBit    (txBit),
    .txLast   (txLast),
    .strb     (strb),
    .txReady  (txReady)
  );

  tx_line_path #(
    .CLKS_PER_BIT (CLKS_PER_BIT),
    .RUN_LIMIT    (RUN_LIMIT)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .tick     (tick),
    .onesFull (onesFull),
    .lineOut  (lineData),
    .enOut    (lineEn),
    .eopOut   (lineEop)
  );

  // R1: idle line rests at J with nothing requested upstream.
  a_r1_idle_rest: assert property (@(posedge clk) disable iff (!rstN)
    !lineEn |-> (lineData && !lineEop && !txReady));

  // R7: ready stays low during the end-of-packet marker.
  a_r7_eop_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    lineEop |-> !txReady);

  // R8: the marker ends into a J bit time with the driver still enabled.
  a_r8_j_after_eop: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lineEop) |-> (lineEn && lineData));

  // R8: the marker drives the line low.
  a_r8_eop_low: assert property (@(posedge clk) disable iff (!rstN)
    lineEop |-> (lineEn && !lineData));

endmodule

// File: tb/sim_usb_nrzi_stuff_tx.sv
`timescale 1ns/1ps
module sim_usb_nrzi_stuff_tx;

  localparam int CLKS = 3;
  localparam int RUN  = 6;
  localparam int SYNC = 8;
  localparam int EOPN = 2;

  typedef struct packed {
    logic en;
    logic eop;
    logic lvl;
    logic rdy;
  } slot_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pktStart = 1'b0;
  logic txBit = 1'b0;
  logic txLast = 1'b0;
  logic txReady, lineData, lineEn, lineEop;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;
  string curTag = "R1";
  slot_t expQ[$];

  always #2 clk = ~clk;

  usb_nrzi_stuff_tx #(
    .CLKS_PER_BIT (CLKS),
    .RUN_LIMIT    (RUN),
    .SYNC_LEN     (SYNC),
    .EOP_BITS     (EOPN)
  ) u0 (
    .clk      (clk),
    .rstN     (rstN),
    .pktStart (pktStart),
    .txBit    (txBit),
    .txLast   (txLast),
    .txReady  (txReady),
    .lineData (lineData),
    .lineEn   (lineEn),
    .lineEop  (lineEop)
  );

  task automatic compareSlot(input string tag, input int slotNo, input slot_t expv);
    slot_t got;
    got = '{en: lineEn, eop: lineEop, lvl: lineData, rdy: txReady};
    vectors++;
    if (got !== expv) begin
      miscompares++;
      $display("FAIL %s slot %0d: got en/eop/lvl/rdy=%b%b%b%b expected %b%b%b%b",
               tag, slotNo, got.en, got.eop, got.lvl, got.rdy,
               expv.en, expv.eop, expv.lvl, expv.rdy);
    end
  endtask

  // Expected line, computed from the requirements (R2..R8).
  task automatic buildExpected(input logic [63:0] data, input int n);
    logic sv[$];
    logic sd[$];
    int   ones = 0;
    logic level = 1'b1;
    for (int i = 0; i < SYNC + n; i++) begin
      logic v;
      v = (i < SYNC) ? (i == SYNC - 1) : data[i - SYNC];
      sv.push_back(v);
      sd.push_back(i >= SYNC);
      ones = v ? ones + 1 : 0;
      if (ones == RUN) begin
        sv.push_back(1'b0);
        sd.push_back(1'b0);
        ones = 0;
      end
    end
    for (int i = 0; i < sv.size(); i++) begin
      level = sv[i] ? level : ~level;
      expQ.push_back('{en: 1'b1, eop: 1'b0, lvl: level,
                       rdy: (i + 1 < sv.size()) && sd[i + 1]});
    end
    for (int i = 0; i < EOPN; i++) expQ.push_back('{en: 1'b1, eop: 1'b1, lvl: 1'b0, rdy: 1'b0});
    expQ.push_back('{en: 1'b1, eop: 1'b0, lvl: 1'b1, rdy: 1'b0});
    expQ.push_back('{en: 1'b0, eop: 1'b0, lvl: 1'b1, rdy: 1'b0});
  endtask

  // Driver: pushes the expected slots, requests the packet and feeds bits.
  task automatic sendPacket(input string tag, input logic [63:0] data, input int n);
    int idx = 0;
    bit wasRdy = 1'b0;
    curTag = tag;
    buildExpected(data, n);
    @(negedge clk);
    pktStart = 1'b1;
    txBit    = data[0];
    txLast   = (n == 1);
    @(negedge clk);
    pktStart = 1'b0;
    while (lineEn) begin
      if (wasRdy && idx < n - 1) begin
        idx++;
        txBit  = data[idx];
        txLast = (idx == n - 1);
      end
      wasRdy = txReady;
      repeat (CLKS) @(negedge clk);
    end
    wait (expQ.size() == 0);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: every clock of every bit time is compared (R10 timing).
  initial begin
    forever begin
      @(negedge clk);
      if (lineEn && expQ.size() > 0) begin
        int slotNo = 0;
        while (expQ.size() > 0) begin
          slot_t e;
          e = expQ.pop_front();
          for (int c = 0; c < CLKS; c++) begin
            compareSlot(curTag, slotNo, e);
            if (c < CLKS - 1) @(negedge clk);
          end
          slotNo++;
          if (expQ.size() > 0) @(negedge clk);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    compareSlot("R1 reset", 0, '{en: 1'b0, eop: 1'b0, lvl: 1'b1, rdy: 1'b0});
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1: idle after reset with no request
    compareSlot("R1 idle", 0, '{en: 1'b0, eop: 1'b0, lvl: 1'b1, rdy: 1'b0});

    sendPacket("R2 R3 R7 R8 R10 mixed", 64'hC35A, 16);
    sendPacket("R4 R7 all ones", 64'h3FFF, 14);
    sendPacket("R5 R6 five ones", 64'h1F, 5);
    sendPacket("R6 tail run", 64'hFC, 8);
    sendPacket("R3 R8 single zero", 64'h0, 1);
    sendPacket("R3 R9 zeros", 64'h0, 10);
    sendPacket("R4 R9 long ones", 64'hFFFF_0FFF, 32);

    // R1: idle again after traffic
    compareSlot("R1 after", 0, '{en: 1'b0, eop: 1'b0, lvl: 1'b1, rdy: 1'b0});
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule